// File: doc/BRIEF.md
# Two-Port Word Memory with Same-Address Arbitration

This block is a synchronous memory of 4096 sixteen-bit words shared by two independent sides, called left and right. Each side has its own enable, write strobe, read gate, two byte-lane write enables, a 12-bit address, write data and registered read data. Either side may read or write any word in any cycle. When both sides address one word in the same cycle, the block grants that word to one side. The other side gets a busy flag in the same cycle, and its write is dropped.

The side that was already sitting on the address in the previous cycle wins. If both sides arrive in the same cycle, left wins. Busy is only raised when at least one of the two colliding accesses is a write. A pure read-read overlap is served on both sides without busy. A strap input selects the arbitration source. As master, the block arbitrates itself and drives its busy outputs. As slave, each side's busy output copies that side's busy input, and the busy input suppresses that side's writes. With the strap, several copies placed side by side for a wider word follow the decision of one master.

Top module: `dpr_top`

## Requirements
- R1: Read data appears one cycle after a cycle with enable high, write low and read gate high, and holds the stored word. After any other cycle the read data is zero.
- R2: On a write, lane enable `*_ub` gates bits 15:8 and `*_lb` gates bits 7:0. A lane whose enable is low keeps its stored value.
- R3: Two accesses to different addresses in one cycle are both carried out, with no busy on either side.
- R4: Two reads of the same address in one cycle both return the stored word, with no busy on either side.
- R5: If one side was enabled on an address in the previous cycle and the other side now arrives at that address with a write involved, the newcomer sees busy in the same cycle and its write is dropped.
- R6: If both sides first arrive at the same address in the same cycle with a write involved, left wins: right sees busy and right's write is dropped.
- R7: Busy on the losing side persists while both sides stay enabled on that address with a write involved. It clears in the cycle the winner leaves the address or drops its enable, and the loser's write then takes effect.
- R8: A read that collides with a same-cycle write by the other side to the same word returns the word as it was before the write.
- R9: In master mode (`master_mode` = 1) the two busy outputs are never high together, and a busy output is high only when both sides are enabled on the same address.
- R10: In slave mode (`master_mode` = 0) each busy output equals that side's busy input in the same cycle. A high busy input drops that side's write, and the internal arbitration has no effect.
- R11: While reset is high, and in the first cycle after it, both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1: local arbitration drives busy; 0: busy taken from inputs |
| l_en | input | 1 | Left access enable |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_oe | input | 1 | Left read gate |
| l_ub | input | 1 | Left upper lane write enable (bits 15:8) |
| l_lb | input | 1 | Left lower lane write enable (bits 7:0) |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, one cycle latency |
| l_busy_in | input | 1 | Left busy input used in slave mode |
| l_busy_out | output | 1 | Left busy flag, always driven |
| r_en | input | 1 | Right access enable |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_oe | input | 1 | Right read gate |
| r_ub | input | 1 | Right upper lane write enable (bits 15:8) |
| r_lb | input | 1 | Right lower lane write enable (bits 7:0) |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, one cycle latency |
| r_busy_in | input | 1 | Right busy input used in slave mode |
| r_busy_out | output | 1 | Right busy flag, always driven |

## Verification
Some properties are checked on every cycle. In master mode the two busy flags are exclusive, and busy only appears on a genuine same-address overlap involving a write. Read-read overlaps never raise busy. A loser that keeps colliding stays busy. In slave mode busy follows the pins, and read data is zero after a cycle without a read. Other behaviour can only be shown by the directed scenarios, because it depends on what ends up stored. That covers which side actually wins, whether a dropped write left the word untouched, and byte-lane merging. It also covers old-data return on a read that collides with a write, and the write that goes through once the winner leaves.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int ADDR_W = 12;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;

    // one side's decoded request for the cycle
    typedef struct packed {
        logic             wr;   // write that survives arbitration
        logic             rd;   // read that loads the output register
        logic [LANES-1:0] be;   // lane write enables, bit 1 = upper
    } side_op_t;

    typedef enum logic {WIN_LEFT = 1'b0, WIN_RIGHT = 1'b1} winner_e;

    function automatic logic same_addr(input logic en_a, input logic en_b,
                                       input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] b);
        return en_a & en_b & (a == b);
    endfunction
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_en,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic          r_en,
    input  logic          r_we,
    input  logic [AW-1:0] r_addr,
    output logic          l_lose,
    output logic          r_lose
);
    logic          l_en_q, r_en_q;
    logic [AW-1:0] l_addr_q, r_addr_q;
    logic          overlap_q;
    winner_e       owner_q;

    logic    overlap, l_held, r_held, hot;
    winner_e winner;

    always_comb begin
        overlap = l_en & r_en & (l_addr == r_addr);
        l_held  = l_en & l_en_q & (l_addr == l_addr_q);
        r_held  = r_en & r_en_q & (r_addr == r_addr_q);
        if (overlap_q && l_held && r_held)
            winner = owner_q;           // contest already decided
        else if (r_held && !l_held)
            winner = WIN_RIGHT;         // right was there first
        else
            winner = WIN_LEFT;          // left first or tie
        hot    = overlap & (l_we | r_we);
        l_lose = hot & (winner == WIN_RIGHT);
        r_lose = hot & (winner == WIN_LEFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_en_q    <= 1'b0;
            r_en_q    <= 1'b0;
            l_addr_q  <= '0;
            r_addr_q  <= '0;
            overlap_q <= 1'b0;
            owner_q   <= WIN_LEFT;
        end else begin
            l_en_q    <= l_en;
            r_en_q    <= r_en;
            l_addr_q  <= l_addr;
            r_addr_q  <= r_addr;
            overlap_q <= overlap;
            owner_q   <= winner;
        end
    end
endmodule

// File: rtl/dpr_array.sv
module dpr_array
    import dpr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LANE_W,
    parameter int NL = LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  side_op_t         a_op,
    input  logic [AW-1:0]    a_addr,
    input  logic [NL*LW-1:0] a_wdata,
    output logic [NL*LW-1:0] a_rdata,
    input  side_op_t         b_op,
    input  logic [AW-1:0]    b_addr,
    input  logic [NL*LW-1:0] b_wdata,
    output logic [NL*LW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = NL * LW;

    logic [DW-1:0] mem [DEPTH];

    // side a (left) written last so it takes precedence if both land
    always_ff @(posedge clk) begin
        for (int g = 0; g < NL; g++) begin
            if (b_op.wr && b_op.be[g]) mem[b_addr][g*LW +: LW] <= b_wdata[g*LW +: LW];
            if (a_op.wr && a_op.be[g]) mem[a_addr][g*LW +: LW] <= a_wdata[g*LW +: LW];
        end
    end

    // registered reads see the pre-write contents
    always_ff @(posedge clk) begin
        if (rst) begin
            a_rdata <= '0;
            b_rdata <= '0;
        end else begin
            a_rdata <= a_op.rd ? mem[a_addr] : '0;
            b_rdata <= b_op.rd ? mem[b_addr] : '0;
        end
    end
endmodule

// File: rtl/dpr_top.sv
module dpr_top
    import dpr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int LW = LANE_W,
    parameter int NL = LANES,
    localparam int DW = NL * LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          master_mode,
    input  logic          l_en,
    input  logic          l_we,
    input  logic          l_oe,
    input  logic          l_ub,
    input  logic          l_lb,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    input  logic          l_busy_in,
    output logic          l_busy_out,
    input  logic          r_en,
    input  logic          r_we,
    input  logic          r_oe,
    input  logic          r_ub,
    input  logic          r_lb,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    input  logic          r_busy_in,
    output logic          r_busy_out
);
    logic     l_lose, r_lose;
    side_op_t l_op, r_op;

    dpr_arbiter #(.AW(AW)) u_arb (
        .clk(clk), .rst(rst),
        .l_en(l_en), .l_we(l_we), .l_addr(l_addr),
        .r_en(r_en), .r_we(r_we), .r_addr(r_addr),
        .l_lose(l_lose), .r_lose(r_lose)
    );

    always_comb begin
        l_busy_out = master_mode ? l_lose : l_busy_in;
        r_busy_out = master_mode ? r_lose : r_busy_in;

        l_op.wr = l_en & l_we & ~l_busy_out;
        l_op.rd = l_en & ~l_we & l_oe;
        l_op.be = {NL{1'b0}};
        r_op.wr = r_en & r_we & ~r_busy_out;
        r_op.rd = r_en & ~r_we & r_oe;
        r_op.be = {NL{1'b0}};
        l_op.be[NL-1] = l_ub;
        l_op.be[0]    = l_lb;
        r_op.be[NL-1] = r_ub;
        r_op.be[0]    = r_lb;
    end

    dpr_array #(.AW(AW), .LW(LW), .NL(NL)) u_mem (
        .clk(clk), .rst(rst),
        .a_op(l_op), .a_addr(l_addr), .a_wdata(l_wdata), .a_rdata(l_rdata),
        .b_op(r_op), .b_addr(r_addr), .b_wdata(r_wdata), .b_rdata(r_rdata)
    );
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          master_mode,
    input logic          l_en,
    input logic          l_we,
    input logic          l_oe,
    input logic [AW-1:0] l_addr,
    input logic [DW-1:0] l_rdata,
    input logic          l_busy_in,
    input logic          l_busy_out,
    input logic          r_en,
    input logic          r_we,
    input logic          r_oe,
    input logic [AW-1:0] r_addr,
    input logic [DW-1:0] r_rdata,
    input logic          r_busy_in,
    input logic          r_busy_out
);
    logic started;
    always_ff @(posedge clk) begin
        if (rst) started <= 1'b0;
        else     started <= 1'b1;
    end

    logic same;
    assign same = l_en & r_en & (l_addr == r_addr);

    p_busy_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        master_mode |-> !(l_busy_out && r_busy_out));

    p_busy_needs_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        (master_mode && (l_busy_out || r_busy_out)) |-> same);

    p_read_pair_free_r4: assert property (@(posedge clk) disable iff (rst)
        (master_mode && same && !l_we && !r_we) |-> (!l_busy_out && !r_busy_out));

    p_loser_sticks_r7: assert property (@(posedge clk) disable iff (rst)
        (started && master_mode && $past(master_mode) && $past(l_busy_out)
         && same && $past(same) && $stable(l_addr) && $stable(r_addr)
         && (l_we || r_we)) |-> l_busy_out);

    p_slave_follow_r10: assert property (@(posedge clk) disable iff (rst)
        !master_mode |-> (l_busy_out == l_busy_in && r_busy_out == r_busy_in));

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (started && !($past(l_en) && !$past(l_we) && $past(l_oe))) |-> (l_rdata == '0));

    p_idle_zero_right_r1: assert property (@(posedge clk) disable iff (rst)
        (started && !($past(r_en) && !$past(r_we) && $past(r_oe))) |-> (r_rdata == '0));
endmodule

bind dpr_top dpr_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_rdata(l_rdata),
    .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
    .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_rdata(r_rdata),
    .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
);

// File: tb/dpr_top_bench.sv
module dpr_top_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic master_mode = 1'b1;
    logic l_en = 0, l_we = 0, l_oe = 0, l_ub = 0, l_lb = 0, l_busy_in = 0;
    logic r_en = 0, r_we = 0, r_oe = 0, r_ub = 0, r_lb = 0, r_busy_in = 0;
    logic [11:0] l_addr = '0, r_addr = '0;
    logic [15:0] l_wdata = '0, r_wdata = '0;
    logic [15:0] l_rdata, r_rdata;
    logic l_busy_out, r_busy_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    dpr_top u_dpr_top (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
        .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // next negedge: previous cycle's read data is now visible
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic lset(input logic en, input logic we, input logic [11:0] a,
                        input logic [15:0] d, input logic ub = 1, input logic lb = 1);
        l_en = en; l_we = we; l_oe = 1; l_addr = a; l_wdata = d; l_ub = ub; l_lb = lb;
    endtask

    task automatic rset(input logic en, input logic we, input logic [11:0] a,
                        input logic [15:0] d, input logic ub = 1, input logic lb = 1);
        r_en = en; r_we = we; r_oe = 1; r_addr = a; r_wdata = d; r_ub = ub; r_lb = lb;
    endtask

    task automatic idle();
        lset(0, 0, 12'd0, 16'h0);
        rset(0, 0, 12'd0, 16'h0);
    endtask

    task automatic t_reset();
        rst = 1; idle();
        tick(); tick();
        chk("R11 left rdata in reset", l_rdata, 16'h0);
        chk("R11 right rdata in reset", r_rdata, 16'h0);
        rst = 0;
        tick();
        chk("R11 left rdata after reset", l_rdata, 16'h0);
        chk("R11 right rdata after reset", r_rdata, 16'h0);
    endtask

    task automatic t_lanes();
        lset(1, 1, 12'd5, 16'hA5C3); tick();
        lset(1, 1, 12'd5, 16'h1100, 1, 0); tick();
        lset(1, 1, 12'd5, 16'h0022, 0, 1); tick();
        lset(1, 0, 12'd5, 16'h0); tick();
        chk("R2 lane merge", l_rdata, 16'h1122);
        lset(1, 0, 12'd5, 16'h0); l_oe = 0; tick();
        chk("R1 read gate low gives zero", l_rdata, 16'h0);
        idle(); tick();
    endtask

    task automatic t_indep();
        lset(1, 1, 12'd10, 16'h1234); rset(1, 1, 12'd20, 16'h5678);
        #1;
        chk("R3 no busy left", {15'd0, l_busy_out}, 16'h0);
        chk("R3 no busy right", {15'd0, r_busy_out}, 16'h0);
        tick();
        lset(1, 0, 12'd20, 16'h0); rset(1, 0, 12'd10, 16'h0); tick();
        chk("R3 left reads right's word", l_rdata, 16'h5678);
        chk("R3 right reads left's word", r_rdata, 16'h1234);
        idle(); tick();
        chk("R1 zero after idle", l_rdata, 16'h0);
    endtask

    task automatic t_dual_read();
        lset(1, 0, 12'd10, 16'h0); rset(1, 0, 12'd10, 16'h0);
        #1;
        chk("R4 read pair no busy", {14'd0, l_busy_out, r_busy_out}, 16'h0);
        tick();
        chk("R4 left data", l_rdata, 16'h1234);
        chk("R4 right data", r_rdata, 16'h1234);
        idle(); tick();
    endtask

    task automatic t_tie();
        lset(1, 1, 12'd30, 16'h1111); rset(1, 1, 12'd30, 16'h2222);
        #1;
        chk("R6 left not busy", {15'd0, l_busy_out}, 16'h0);
        chk("R6 right busy", {15'd0, r_busy_out}, 16'h1);
        tick(); idle(); tick();
        lset(1, 0, 12'd30, 16'h0); tick();
        chk("R6 left data kept", l_rdata, 16'h1111);
        idle(); tick();
    endtask

    task automatic t_earlier();
        lset(1, 1, 12'd40, 16'h4040); tick();
        idle(); tick();
        rset(1, 0, 12'd40, 16'h0); tick();
        lset(1, 1, 12'd40, 16'hBEEF);
        #1;
        chk("R5 newcomer busy", {15'd0, l_busy_out}, 16'h1);
        chk("R5 holder free", {15'd0, r_busy_out}, 16'h0);
        tick();
        chk("R5 holder reads old", r_rdata, 16'h4040);
        rset(1, 1, 12'd40, 16'h7777); lset(1, 1, 12'd40, 16'hDEAD);
        #1;
        chk("R7 loser stays busy", {15'd0, l_busy_out}, 16'h1);
        chk("R7 winner free", {15'd0, r_busy_out}, 16'h0);
        tick();
        rset(0, 0, 12'd0, 16'h0); lset(1, 1, 12'd40, 16'hCAFE);
        #1;
        chk("R7 busy clears when winner leaves", {15'd0, l_busy_out}, 16'h0);
        tick();
        lset(1, 0, 12'd40, 16'h0); tick();
        chk("R7 loser write lands", l_rdata, 16'hCAFE);
        idle(); tick();
    endtask

    task automatic t_old_data();
        lset(1, 1, 12'd50, 16'h0505); tick();
        idle(); tick();
        lset(1, 1, 12'd50, 16'h5A5A); rset(1, 0, 12'd50, 16'h0);
        #1;
        chk("R8 reader busy", {15'd0, r_busy_out}, 16'h1);
        tick();
        chk("R8 collided read returns old", r_rdata, 16'h0505);
        lset(0, 0, 12'd0, 16'h0); rset(1, 0, 12'd50, 16'h0); tick();
        chk("R8 later read returns new", r_rdata, 16'h5A5A);
        idle(); tick();
    endtask

    task automatic t_slave();
        master_mode = 0;
        lset(1, 1, 12'd60, 16'h0606); tick();
        lset(1, 1, 12'd60, 16'h6666); rset(1, 1, 12'd60, 16'h9999);
        l_busy_in = 1; r_busy_in = 0;
        #1;
        chk("R10 left follows input", {15'd0, l_busy_out}, 16'h1);
        chk("R10 right follows input", {15'd0, r_busy_out}, 16'h0);
        tick();
        l_busy_in = 0;
        rset(0, 0, 12'd0, 16'h0); lset(1, 0, 12'd60, 16'h0); tick();
        chk("R10 blocked left, right wrote", l_rdata, 16'h9999);
        idle(); tick();
        master_mode = 1;
    endtask

    initial begin
        t_reset();
        t_lanes();
        t_indep();
        t_dual_read();
        t_tie();
        t_earlier();
        t_old_data();
        t_slave();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule